// File: doc/BRIEF.md
# SHA-1 Message Schedule Window

This block supplies the eighty 32-bit message words that a SHA-1 compression core uses, one word per round. It needs only sixteen 32-bit registers to do so. When a new 512-bit block starts, a load pulse copies the block into the window. Each later step pulse moves the schedule forward by one round. The word for the current round is always present on `word_o`.

An internal round counter runs from 0 to 79 and picks the source of the output. During rounds 0 to 15 the output is read straight from the loaded words. From round 16 onward, every step computes a new word from four taps of the window. That word is rotated left by one bit, appended as the newest entry, and the oldest entry is dropped.

Once round 79 has been stepped past, the block goes idle. It then ignores step pulses until the next load. Round sequencing and the hash arithmetic belong to the surrounding core.

Top module: `msg_sched_window`

## Requirements
- R1: An active-low `rst_n` clears the block at once, without waiting for a clock edge. After reset `valid_o` is 0 and `word_o` is 0.
- R2: A clock edge with `load_i` high starts a block. After that edge `valid_o` is 1 and `word_o` equals `block_i[511:480]`.
- R3: In rounds 0 to 15, the word for round t is `block_i[511-32*t -: 32]`. Word 0 is therefore in the most significant bits.
- R4: In rounds 16 to 79, the word for round t is the XOR of the words for rounds t-3, t-8, t-14 and t-16, rotated left by one bit.
- R5: An edge with `step_i` high, while `valid_o` is 1, advances the output to the next round. An edge with `step_i` low leaves `word_o` unchanged.
- R6: A step taken while the round-79 word is shown sets `valid_o` to 0. `word_o` keeps showing the round-79 word.
- R7: While `valid_o` is 0 and `load_i` is low, `step_i` and `block_i` have no effect on `word_o` or `valid_o`.
- R8: `load_i` takes priority over `step_i`. A load in any round, including one on the same edge as a step, restarts at round 0 with the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture `block_i` and restart at round 0 |
| step_i | input | 1 | Advance one round |
| block_i | input | 512 | Message block, word 0 in the top bits |
| word_o | output | 32 | Message word for the current round |
| valid_o | output | 1 | A block is in progress |

## Verification
The behaviour that is hardest to reach from the ports is the late part of the schedule. At that point every entry in the window has been recomputed several times, so an error in a single tap shows up only many rounds later. It also takes 79 steps to reach the end-of-block transition. The stimulus therefore walks several blocks with different bit patterns through all eighty rounds, and inserts pause cycles at varying intervals. It also fires a load on the same edge as a step in the middle of the expansion phase, and checks the words that follow that restart.

// File: rtl/msg_sched_window.sv
module msg_sched_window #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  parameter int ROUNDS = 80
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic                      step_i,
  input  logic [WORD_W*DEPTH-1:0]   block_i,
  output logic [WORD_W-1:0]         word_o,
  output logic                      valid_o
);
  localparam int CW = $clog2(ROUNDS);
  localparam int IW = $clog2(DEPTH);
  localparam int BW = WORD_W * DEPTH;

  logic [WORD_W-1:0] win [DEPTH];
  logic [CW-1:0]     cnt;
  logic              busy;

  wire adv  = busy & step_i & ~load_i;
  wire last = (cnt == CW'(ROUNDS - 1));
  wire fill = (cnt >= CW'(DEPTH - 1));
  wire [WORD_W-1:0] mix = win[DEPTH-3] ^ win[DEPTH-8] ^ win[DEPTH-14] ^ win[0];
  wire [WORD_W-1:0] nxt = {mix[WORD_W-2:0], mix[WORD_W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) win[i] <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load_i) begin
      for (int i = 0; i < DEPTH; i++) win[i] <= block_i[BW-1-WORD_W*i -: WORD_W];
      cnt  <= '0;
      busy <= 1'b1;
    end else if (adv) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (fill) begin
          for (int i = 0; i < DEPTH - 1; i++) win[i] <= win[i+1];
          win[DEPTH-1] <= nxt;
        end
      end
    end
  end

  assign word_o  = (cnt < CW'(DEPTH)) ? win[cnt[IW-1:0]] : win[DEPTH-1];
  assign valid_o = busy;

  assert_round_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(ROUNDS - 1));

  assert_load_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> valid_o && word_o == $past(block_i[BW-1 -: WORD_W]));

  assert_pause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i && !load_i |=> $stable(word_o) && $stable(valid_o));

  assert_idle_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o && !load_i |=> !valid_o && $stable(word_o));

  assert_block_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && step_i && !load_i && last |=> !valid_o && $stable(word_o));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && step_i |=> valid_o && cnt == '0);
endmodule

// File: tb/sim_msg_sched_window.sv
module sim_msg_sched_window;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic         step_i = 1'b0;
  logic [511:0] block_i = '0;
  logic [31:0]  word_o;
  logic         valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] ew [80];

  localparam int NV = 4;
  localparam logic [511:0] BLK [NV] = '{
    {32'h61626380, {14{32'h0}}, 32'h00000018},
    {16{32'hffffffff}},
    {8{64'h0123456789abcdef}},
    {4{128'h80000001_00000000_deadbeef_5a5aa5a5}}
  };
  localparam int GAP [NV] = '{0, 3, 7, 11};

  msg_sched_window u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
    .block_i(block_i), .word_o(word_o), .valid_o(valid_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build(input logic [511:0] b);
    for (int i = 0; i < 16; i++) ew[i] = b[511-32*i -: 32];
    for (int i = 16; i < 80; i++) begin
      logic [31:0] x;
      x = ew[i-3] ^ ew[i-8] ^ ew[i-14] ^ ew[i-16];
      ew[i] = {x[30:0], x[31]};
    end
  endtask

  task automatic load_blk(input logic [511:0] b);
    build(b);
    @(negedge clk);
    block_i = b;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    chk({31'b0, valid_o}, 32'd1, "R2 valid after load");
    chk(word_o, ew[0], "R2 first word");
  endtask

  initial begin
    #1;
    chk({31'b0, valid_o}, 32'd0, "R1 reset valid");
    chk(word_o, 32'd0, "R1 reset word");
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      load_blk(BLK[v]);
      for (int t = 0; t < 80; t++) begin
        chk(word_o, ew[t], t < 16 ? $sformatf("R3 v%0d t%0d", v, t) : $sformatf("R4 v%0d t%0d", v, t));
        if (GAP[v] != 0 && (t % GAP[v]) == GAP[v] - 1) begin
          step_i = 1'b0;
          @(negedge clk);
          chk(word_o, ew[t], $sformatf("R5 pause v%0d t%0d", v, t));
        end
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
      end
      chk({31'b0, valid_o}, 32'd0, "R6 valid drops");
      chk(word_o, ew[79], "R6 last word held");
    end

    step_i = 1'b1;
    block_i = ~BLK[0];
    repeat (5) @(negedge clk);
    step_i = 1'b0;
    chk({31'b0, valid_o}, 32'd0, "R7 idle valid");
    chk(word_o, ew[79], "R7 idle word");

    load_blk(BLK[2]);
    for (int t = 0; t < 20; t++) begin
      step_i = 1'b1;
      @(negedge clk);
    end
    chk(word_o, ew[20], "R4 before restart");
    build(BLK[3]);
    block_i = BLK[3];
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    chk({31'b0, valid_o}, 32'd1, "R8 valid after restart");
    chk(word_o, ew[0], "R8 restart word 0");
    for (int t = 1; t < 24; t++) begin
      @(negedge clk);
      chk(word_o, ew[t], $sformatf("R8 after restart t%0d", t));
    end
    step_i = 1'b0;

    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk({31'b0, valid_o}, 32'd0, "R1 async valid");
    chk(word_o, 32'd0, "R1 async word");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule